// File: doc/BRIEF.md
# Programmable Interval Timer Channel

A single 16-bit down-counting timer channel clocked by a fixed count clock. A separate control block hands it a reload value, a three-bit mode, a binary/BCD select and a one-cycle load strobe. The channel then shapes its output pin according to the selected mode: a one-shot timeout, a gate-triggered one-shot, a periodic rate generator, a square wave, or a strobe that is started either by software or by the gate input.

Every rising edge of `clk` is one count clock. The current count and a count-loaded flag are exported so that a readback block can latch them. Host port decoding, readback latching, byte sequencing and anything downstream of the output pin belong to other blocks.

Top module: `pit_channel`

## Requirements
- R1: After reset, `out` is 1, `count` is 0 and `loaded` is 0, and the channel stays idle until a load.
- R2: A clock edge with `load` high captures `reload`, `mode` and `bcd`. On that edge `count` takes the reload value (in the square-wave modes, the value with bit 0 cleared) and `loaded` is set. `out` becomes 0 in mode 0 and 1 in every other mode. Counting starts on the next edge, except in modes 1 and 5.
- R3: Mode 0 (code 000) decrements once per edge while `gate` is 1 and holds while `gate` is 0. On the edge where the count reaches 0, `out` goes to 1 and `loaded` clears. After that the channel stops until the next load.
- R4: Mode 1 (code 001) keeps `out` at 1 after a load and waits. A rising `gate` reloads the count and drives `out` to 0. The count then decrements on every edge whatever `gate` does. At 0, `out` returns to 1 and `loaded` clears, so `out` stays low for N clocks.
- R5: Mode 2 (code 010) has period N clocks. `out` is 0 only while the count is 1, and the next edge reloads N and sets `out` to 1. While `gate` is 0, counting halts and `out` is forced to 1.
- R6: Mode 3 (code 011) decrements by two per gated edge and reloads automatically. An even N gives N/2 clocks high then N/2 low. An odd N gives (N+1)/2 high then (N-1)/2 low. `count` is always even, and counting halts while `gate` is 0.
- R7: Mode 4 (code 100) keeps `out` at 1 and decrements while `gate` is 1. On reaching 0 it drives `out` to 0 for exactly one clock and clears `loaded`, with no reload.
- R8: Mode 5 (code 101) keeps `out` at 1 and waits for a rising `gate`. It then reloads and counts on every edge whatever `gate` does. At 0 it pulses `out` low for one clock and clears `loaded`, with no reload.
- R9: With `bcd` = 1, the count steps through four decimal digits, one per nibble with the least significant digit in bits 3:0, each 0 to 9. All modes behave as in binary with the decimal value N.
- R10: Mode codes 110 and 111 behave as modes 2 and 3.
- R11: In modes 1 and 5, once counting has begun, neither a falling nor a new rising `gate` changes the count or the end time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Count clock; one count per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| gate | input | 1 | Gate: enables counting or triggers, depending on mode |
| load | input | 1 | One-cycle strobe that captures the new setup |
| reload | input | 16 | Reload value (binary or four BCD digits) |
| mode | input | 3 | Counting mode code |
| bcd | input | 1 | 1 selects decimal counting |
| out | output | 1 | Timer output pin |
| count | output | 16 | Current count value |
| loaded | output | 1 | Set by a load, cleared when a one-shot mode expires |

## Verification
The assertions assume that every reload value is at least 2. They also assume that, when `bcd` is 1, every nibble of the reload value is a legal decimal digit. They further assume that `load` is a single-cycle strobe. The stimulus keeps to these limits: it sweeps reload values from 2 to 9 in binary and uses only well-formed decimal values such as 10, 11 and 12. It drives `gate` and `load` only on falling clock edges, so each rising edge sees settled inputs and the gate edge detector sees clean transitions.

// File: rtl/pit_channel.sv
module pit_channel #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         gate,
  input  logic         load,
  input  logic [W-1:0] reload,
  input  logic [2:0]   mode,
  input  logic         bcd,
  output logic         out,
  output logic [W-1:0] count,
  output logic         loaded
);
  localparam int ND = W / 4;

  function automatic logic [2:0] fold(input logic [2:0] m);
    return (m[2:1] == 2'b11) ? {1'b0, m[1:0]} : m;
  endfunction

  function automatic logic [W-1:0] bcd_dec(input logic [W-1:0] v);
    logic [W-1:0] r;
    logic borrow;
    r = v;
    borrow = 1'b1;
    for (int i = 0; i < ND; i++) begin
      if (borrow) begin
        if (v[4*i +: 4] == 4'd0) r[4*i +: 4] = 4'd9;
        else begin
          r[4*i +: 4] = v[4*i +: 4] - 4'd1;
          borrow = 1'b0;
        end
      end
    end
    return r;
  endfunction

  function automatic logic digits_ok(input logic [W-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < ND; i++) if (v[4*i +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  logic [W-1:0] cnt, rld;
  logic [2:0]   mode_r;
  logic         bcd_r, out_r, run, gate_q;

  wire [2:0]   em    = fold(mode_r);
  wire [2:0]   em_in = fold(mode);
  wire         rise  = gate & ~gate_q;
  wire [W-1:0] dec1  = bcd_r ? bcd_dec(cnt) : cnt - W'(1);
  wire [W-1:0] dec2  = bcd_r ? bcd_dec(bcd_dec(cnt)) : cnt - W'(2);
  wire [W-1:0] even_rld = {rld[W-1:1], 1'b0};
  wire [W-1:0] term  = (out_r && rld[0]) ? '0 : W'(2);

  assign out   = out_r;
  assign count = cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0; rld <= '0; mode_r <= '0; bcd_r <= 1'b0;
      out_r <= 1'b1; run <= 1'b0; loaded <= 1'b0; gate_q <= 1'b0;
    end else begin
      gate_q <= gate;
      if (load) begin
        rld    <= reload;
        mode_r <= mode;
        bcd_r  <= bcd;
        loaded <= 1'b1;
        cnt    <= (em_in == 3'd3) ? {reload[W-1:1], 1'b0} : reload;
        out_r  <= (em_in != 3'd0);
        run    <= !(em_in == 3'd1 || em_in == 3'd5);
      end else begin
        case (em)
          3'd0: if (run && gate) begin
            cnt <= dec1;
            if (cnt == W'(1)) begin
              out_r <= 1'b1; run <= 1'b0; loaded <= 1'b0;
            end
          end
          3'd1, 3'd5: begin
            if (!run) begin
              if (em == 3'd5 && !out_r) out_r <= 1'b1;
              else if (rise) begin
                cnt <= rld; run <= 1'b1; out_r <= (em == 3'd5);
              end
            end else begin
              cnt <= dec1;
              if (cnt == W'(1)) begin
                run <= 1'b0; loaded <= 1'b0; out_r <= (em == 3'd1);
              end
            end
          end
          3'd2: begin
            if (!gate) out_r <= 1'b1;
            else if (cnt == W'(1)) begin
              cnt <= rld; out_r <= 1'b1;
            end else begin
              cnt <= dec1;
              if (cnt == W'(2)) out_r <= 1'b0;
            end
          end
          3'd3: if (gate) begin
            if (cnt == term) begin
              cnt <= even_rld; out_r <= ~out_r;
            end else cnt <= dec2;
          end
          3'd4: begin
            if (!run) begin
              if (!out_r) out_r <= 1'b1;
            end else if (gate) begin
              cnt <= dec1;
              if (cnt == W'(1)) begin
                out_r <= 1'b0; run <= 1'b0; loaded <= 1'b0;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R6, R10: square-wave count is never odd
  assert_sq_even_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (em == 3'd3) |-> !cnt[0]);

  // R5, R7, R8: a low output lasts one clock in rate and strobe modes
  assert_one_clk_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_r && !load && (em == 3'd2 || em == 3'd4 || em == 3'd5)) |=> out_r);

  // R3: after a mode 0 timeout the output stays high until a new load
  assert_timeout_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (em == 3'd0 && out_r && !load) |=> out_r);

  // R9: decimal counting keeps every digit legal
  assert_bcd_digits_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bcd_r |-> digits_ok(cnt));

  // R4: the loaded flag clears only on expiry at zero
  assert_loaded_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(loaded) |-> (cnt == '0));
endmodule

// File: tb/test_pit_channel.sv
`timescale 1ns/1ps
module test_pit_channel;
  logic clk = 1'b0, rst_n = 1'b0, gate = 1'b0, load = 1'b0, bcd = 1'b0;
  logic [15:0] reload = '0;
  logic [2:0] mode = '0;
  logic out, loaded;
  logic [15:0] count;
  int checks = 0, errors = 0;

  pit_channel i_pit_channel (.clk(clk), .rst_n(rst_n), .gate(gate), .load(load),
    .reload(reload), .mode(mode), .bcd(bcd), .out(out), .count(count), .loaded(loaded));

  always #4 clk = ~clk;

  function automatic int to_bcd(input int v);
    return ((v / 1000) % 10) * 4096 + ((v / 100) % 10) * 256 + ((v / 10) % 10) * 16 + (v % 10);
  endfunction

  // expected state k edges after a load (modes 0,2,3,4,6,7) or after the trigger (1,5)
  function automatic void model(input int m, input int r, input int k,
                                output bit eo, output int ec, output bit el);
    int p, h, e;
    case (m)
      0, 1: begin eo = (k >= r); ec = (k < r) ? r - k : 0; el = (k < r); end
      4, 5: begin eo = (k != r); ec = (k < r) ? r - k : 0; el = (k < r); end
      2, 6: begin p = k % r; ec = r - p; eo = (ec != 1); el = 1'b1; end
      default: begin
        e = r - (r % 2); h = (r + 1) / 2; p = k % r;
        eo = (p < h); ec = (p < h) ? e - 2 * p : e - 2 * (p - h); el = 1'b1;
      end
    endcase
  endfunction

  task automatic check(input string req, input bit eo, input int ec, input bit el, input bit dec);
    int exp_c;
    exp_c = dec ? to_bcd(ec) : ec;
    checks++;
    if (out !== eo || count !== exp_c[15:0] || loaded !== el) begin
      errors++;
      $display("FAIL %s: out=%0b count=%h loaded=%0b, expected out=%0b count=%h loaded=%0b",
               req, out, count, loaded, eo, exp_c[15:0], el);
    end
  endtask

  task automatic do_load(input int r, input int m, input bit dec);
    @(negedge clk);
    load = 1'b1; reload = dec ? 16'(to_bcd(r)) : 16'(r); mode = 3'(m); bcd = dec;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic run_free(input string req, input int m, input int r, input bit dec);
    bit eo, el; int ec;
    gate = 1'b1;
    do_load(r, m, dec);
    for (int k = 0; k <= 3 * r + 1; k++) begin
      model(m, r, k, eo, ec, el);
      check(req, eo, ec, el, dec);
      @(negedge clk);
    end
  endtask

  task automatic run_trig(input string req, input int m, input int r, input bit bounce);
    bit eo, el; int ec;
    gate = 1'b0;
    do_load(r, m, 1'b0);
    for (int i = 0; i < 2; i++) begin
      check(req, 1'b1, r, 1'b1, 1'b0);   // waiting for the gate
      @(negedge clk);
    end
    gate = 1'b1;
    @(negedge clk);
    for (int j = 0; j <= r + 2; j++) begin
      model(m, r, j, eo, ec, el);
      check(req, eo, ec, el, 1'b0);
      if (j == 1) gate = 1'b0;
      if (j == 2 && bounce) gate = 1'b1;  // R11: new rise mid-count
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int modes[6] = '{0, 2, 3, 4, 6, 7};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 1'b1, 0, 1'b0, 1'b0);
    @(negedge clk);
    check("R1", 1'b1, 0, 1'b0, 1'b0);

    // R2 R3 R5 R6 R7 R10: sweep free-running modes
    foreach (modes[i])
      for (int r = 2; r <= 9; r++)
        run_free(modes[i] >= 6 ? "R10" : modes[i] == 0 ? "R3" : modes[i] == 2 ? "R5" :
                 modes[i] == 3 ? "R6" : "R7", modes[i], r, 1'b0);

    // R4 R8 R11: gate-triggered modes
    for (int r = 2; r <= 9; r++) begin
      run_trig("R4", 1, r, 1'b0);
      run_trig("R8", 5, r, 1'b0);
    end
    run_trig("R11", 1, 6, 1'b1);
    run_trig("R11", 5, 5, 1'b1);

    // R9: decimal counting
    run_free("R9", 0, 12, 1'b1);
    run_free("R9", 2, 10, 1'b1);
    run_free("R9", 3, 11, 1'b1);
    run_free("R9", 4, 10, 1'b1);

    // R3: gate low pauses mode 0
    gate = 1'b1; do_load(5, 0, 1'b0);
    repeat (2) @(negedge clk);
    gate = 1'b0;
    for (int i = 0; i < 3; i++) begin @(negedge clk); check("R3", 1'b0, 3, 1'b1, 1'b0); end
    gate = 1'b1;
    for (int i = 1; i <= 3; i++) begin @(negedge clk); check("R3", i == 3, 3 - i, i != 3, 1'b0); end

    // R5: gate low while output is low forces it high and halts
    gate = 1'b1; do_load(4, 2, 1'b0);
    repeat (3) @(negedge clk);
    check("R5", 1'b0, 1, 1'b1, 1'b0);
    gate = 1'b0;
    for (int i = 0; i < 2; i++) begin @(negedge clk); check("R5", 1'b1, 1, 1'b1, 1'b0); end
    gate = 1'b1;
    @(negedge clk); check("R5", 1'b1, 4, 1'b1, 1'b0);
    @(negedge clk); check("R5", 1'b1, 3, 1'b1, 1'b0);

    // R6: square wave holds while gate is low
    gate = 1'b1; do_load(6, 3, 1'b0);
    @(negedge clk);
    gate = 1'b0;
    for (int i = 0; i < 2; i++) begin @(negedge clk); check("R6", 1'b1, 4, 1'b1, 1'b0); end

    // R7: strobe count holds while gate is low
    gate = 1'b1; do_load(5, 4, 1'b0);
    @(negedge clk);
    gate = 1'b0;
    for (int i = 0; i < 2; i++) begin @(negedge clk); check("R7", 1'b1, 4, 1'b1, 1'b0); end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule